// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a two-slope integrating analog-to-digital converter. It drives the analog switches around an external integrator and counts clock ticks. A start request begins a conversion. The block first closes a zeroing switch for a fixed number of cycles, which brings the integrator to the comparator threshold. It then closes the input switch for exactly 2^N cycles, where N is the result width. Last, it closes the reference switch, which discharges the integrator at a constant current, and counts cycles until the comparator reports that the threshold has been reached again.

Both the fixed charge window and the discharge count are timed by the same clock. An error in the clock frequency therefore scales both slopes equally and cancels out. Each conversion starts and ends at the comparator threshold, so the comparator offset also cancels. The discharge count is the conversion result. A full-scale input produces a count of 2^N. The result width `RES_BITS` is a parameter that is used from 4 up to 18 bits, and its default is 12. The length of the zeroing phase is set by `AZ_CYCLES`.

The integrator, the current sources and the comparator are outside the block. The testbench models them.

Top module: `dsadc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, the block is idle. All three switch outputs are low, `busy_o` is 0, `done_o` is 0, `result_o` is 0 and `ovr_o` is 0.
- R2: A high `start_i` sampled while the block is idle begins a conversion with the zeroing phase. In this phase `sw_zero_o` is high for exactly `AZ_CYCLES` consecutive cycles, and it is the first switch that closes.
- R3: Right after the zeroing phase, `sw_input_o` is high for exactly 2^`RES_BITS` consecutive cycles.
- R4: Right after the charge phase, `sw_ref_o` goes high. `cmp_i` (1 = integrator has reached the threshold) is acted on only while `sw_ref_o` is high. A high `cmp_i` during idle, zeroing or charge has no effect.
- R5: Let K be the number of discharge cycles before the first cycle in which `cmp_i` is high. Then `sw_ref_o` is high for K+1 cycles, and for K < 2^`RES_BITS` the result is K.
- R6: If K equals 2^`RES_BITS`, the result saturates to all ones and `ovr_o` is 0.
- R7: If `cmp_i` stays low for 2^`RES_BITS`+1 discharge cycles, the conversion stops after those cycles. `result_o` becomes all ones and `ovr_o` becomes 1.
- R8: `done_o` is a single-cycle pulse. It is raised in the first cycle after the discharge ends, which is the same cycle in which `result_o` and `ovr_o` take their new values. Both outputs then hold those values until the next `done_o`.
- R9: A high `start_i` while a conversion is running has no effect. The phase lengths are unchanged, and no new conversion follows the `done_o` pulse.
- R10: At most one switch output is high at any time, and `busy_o` is high exactly while one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times both slopes |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator: 1 = integrator has reached the threshold |
| sw_zero_o | output | 1 | Closes the integrator zeroing switch |
| sw_input_o | output | 1 | Closes the input integrate switch |
| sw_ref_o | output | 1 | Closes the reference discharge switch |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle strobe: a new result is valid |
| result_o | output | RES_BITS | Discharge count, saturated to all ones |
| ovr_o | output | 1 | Comparator did not trip within the discharge window |

## Verification
The modelled comparator trips after every discharge length K from 0 to two beyond full scale, using a 4-bit configuration. This sweep separates the in-range counts from the exact full-scale saturation case and from the overrange timeout, because each of those three produces a different `sw_ref_o` length and a different `ovr_o` value. The case K = 0 holds `cmp_i` high through the idle, zeroing and charge phases, which shows that the comparator is ignored outside discharge. Further runs inject a start request in the middle of the charge phase and assert reset in the middle of a conversion. These show that the phase lengths stay fixed and that the switches open at once on reset.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ZERO   = 2'd1,
    PH_CHARGE = 2'd2,
    PH_DISCH  = 2'd3
  } phase_e;
endpackage

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int AZ_CYCLES = 8,
  parameter int CNT_W     = RES_BITS + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] tick_o,
  output logic             finish_o,
  output logic             trip_o
);
  // Last tick index of each timed phase.
  function automatic logic [CNT_W-1:0] phase_last(input phase_e ph);
    case (ph)
      PH_ZERO:   return CNT_W'(AZ_CYCLES - 1);
      PH_CHARGE: return CNT_W'((2 ** RES_BITS) - 1);
      PH_DISCH:  return CNT_W'(2 ** RES_BITS);
      default:   return '0;
    endcase
  endfunction

  phase_e           phase_q;
  logic [CNT_W-1:0] tick_q;
  logic             at_last;

  assign at_last  = (tick_q == phase_last(phase_q));
  assign trip_o   = (phase_q == PH_DISCH) && cmp_i;
  assign finish_o = (phase_q == PH_DISCH) && (cmp_i || at_last);
  assign phase_o  = phase_q;
  assign tick_o   = tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      tick_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          tick_q <= '0;
          if (start_i) phase_q <= PH_ZERO;
        end
        PH_ZERO, PH_CHARGE: begin
          if (at_last) begin
            tick_q  <= '0;
            phase_q <= (phase_q == PH_ZERO) ? PH_CHARGE : PH_DISCH;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: begin
          if (finish_o) begin
            tick_q  <= '0;
            phase_q <= PH_IDLE;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && !finish_o && start_i) |=> (phase_q != PH_IDLE));

  // R3
  charge_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CHARGE) |-> (tick_q < CNT_W'(2 ** RES_BITS)));

  // R7
  disch_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DISCH) |-> (tick_q <= CNT_W'(2 ** RES_BITS)));
endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture #(
  parameter int RES_BITS = 12,
  parameter int CNT_W    = RES_BITS + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                finish_i,
  input  logic                trip_i,
  input  logic [CNT_W-1:0]    tick_i,
  output logic [RES_BITS-1:0] result_o,
  output logic                ovr_o,
  output logic                done_o
);
  localparam logic [RES_BITS-1:0] FULL = '1;

  // Clamp a discharge count to the result width.
  function automatic logic [RES_BITS-1:0] clamp_count(input logic [CNT_W-1:0] n);
    if (n > CNT_W'(FULL)) return FULL;
    return n[RES_BITS-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        result_o <= trip_i ? clamp_count(tick_i) : FULL;
        ovr_o    <= !trip_i;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !finish_i |=> $stable(result_o) && $stable(ovr_o));

  // R7
  ovr_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && ovr_o) |-> (result_o == FULL));
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int RES_BITS  = 12,
  parameter int AZ_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cmp_i,
  output logic                sw_zero_o,
  output logic                sw_input_o,
  output logic                sw_ref_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                ovr_o
);
  localparam int AZ_W  = $clog2(AZ_CYCLES + 1) + 1;
  localparam int CNT_W = (RES_BITS + 2 > AZ_W) ? RES_BITS + 2 : AZ_W;

  phase_e           phase;
  logic [CNT_W-1:0] tick;
  logic             finish_evt;
  logic             trip_evt;

  dsadc_seq #(
    .RES_BITS (RES_BITS),
    .AZ_CYCLES(AZ_CYCLES),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cmp_i   (cmp_i),
    .phase_o (phase),
    .tick_o  (tick),
    .finish_o(finish_evt),
    .trip_o  (trip_evt)
  );

  dsadc_capture #(
    .RES_BITS(RES_BITS),
    .CNT_W   (CNT_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .finish_i(finish_evt),
    .trip_i  (trip_evt),
    .tick_i  (tick),
    .result_o(result_o),
    .ovr_o   (ovr_o),
    .done_o  (done_o)
  );

  assign sw_zero_o  = (phase == PH_ZERO);
  assign sw_input_o = (phase == PH_CHARGE);
  assign sw_ref_o   = (phase == PH_DISCH);
  assign busy_o     = (phase != PH_IDLE);

  // R10
  switch_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sw_zero_o, sw_input_o, sw_ref_o}));

  // R10
  busy_switch_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o == (sw_zero_o || sw_input_o || sw_ref_o));

  // R3
  charge_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_input_o) |-> $past(sw_zero_o));

  // R5
  done_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(sw_ref_o));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !ovr_o));
endmodule

// File: tb/dsadc_ctrl_tb.sv
module dsadc_ctrl_tb;
  localparam int N    = 4;
  localparam int AZ   = 3;
  localparam int FS   = 2 ** N;
  localparam int MAXV = FS - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cmp_i;
  logic sw_zero_o, sw_input_o, sw_ref_o, busy_o, done_o, ovr_o;
  logic [N-1:0] result_o;

  int checks = 0;
  int failures = 0;
  int k_cfg = 0;
  int ref_cnt = 0;

  always #5 clk = ~clk;

  dsadc_ctrl #(.RES_BITS(N), .AZ_CYCLES(AZ)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .sw_zero_o(sw_zero_o), .sw_input_o(sw_input_o), .sw_ref_o(sw_ref_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .ovr_o(ovr_o)
  );

  // Integrator/comparator model: trips after k_cfg reference cycles.
  always @(posedge clk) ref_cnt <= sw_ref_o ? ref_cnt + 1 : 0;
  assign cmp_i = (ref_cnt >= k_cfg);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check_idle(input string req);
    check(req, {sw_zero_o, sw_input_o, sw_ref_o}, 0);
    check(req, busy_o, 0);
    check(req, done_o, 0);
  endtask

  task automatic convert(input int k, input bit inject);
    int z = 0, c = 0, d = 0, guard = 0;
    bit seen_zero_first = 0;
    k_cfg = k;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      if (done_o) break;
      if (sw_zero_o && c == 0 && d == 0) seen_zero_first = 1;
      if (sw_zero_o) z++;
      if (sw_input_o) c++;
      if (sw_ref_o) d++;
      guard++;
      if (guard > 200) begin
        check("R8 done timeout", 0, 1);
        return;
      end
      @(negedge clk);
      start_i = (inject && c == 5 && sw_input_o) ? 1'b1 : 1'b0;
    end
    start_i = 1'b0;
    check("R2 zero length", z, AZ);
    check("R2 zero first", seen_zero_first, 1);
    check("R3 charge length", c, FS);
    check("R5 ref length", d, (k <= FS) ? k + 1 : FS + 1);
    if (k < FS) check("R5 result", result_o, k);
    else if (k == FS) check("R6 full-scale result", result_o, MAXV);
    else check("R7 overrange result", result_o, MAXV);
    check((k > FS) ? "R7 ovr flag" : "R6 ovr flag", ovr_o, (k > FS) ? 1 : 0);
    @(negedge clk);
    check("R8 done one cycle", done_o, 0);
    check("R8 result held", result_o, (k < FS) ? k : MAXV);
    check("R10 busy after end", busy_o, 0);
    if (inject) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check("R9 no restart", busy_o, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    check("R1 reset result", result_o, 0);
    check("R1 reset ovr", ovr_o, 0);
    rst = 1'b0;
    // R4: K=0 keeps cmp_i high through idle, zero and charge phases.
    for (int k = 0; k <= FS + 2; k++) convert(k, 1'b0);
    convert(7, 1'b1);
    convert(FS + 1, 1'b1);
    // R1: reset in the middle of a conversion.
    k_cfg = 9;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (AZ + 4) @(negedge clk);
    check("R1 mid-run charging", sw_input_o, 1);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 mid-run reset");
    rst = 1'b0;
    convert(5, 1'b0);
    finish_run();
  end
endmodule